// File: doc/BRIEF.md
# Capacitive Key Matrix Scanner with Confirming Re-read

This block scans a capacitive key matrix of ROWS drive lines and COLS sense columns (12 by 8 by default). It does not sense anything itself. It sequences an external sense amplifier through a fixed handshake for every sensor. The amplifier has a select input that carries either a column address or a threshold code, a strobe line Q, an enable/reset line and an output that reads low when the addressed sensor is closed. The scanner builds one word per row from the eight samples and compares that word with a stored row map.

A row whose word differs from the map is read a second time. The map takes the new word only when both reads agree. A pair of reads that disagree is treated as noise and dropped. Rows that hold keys, or that change state, are handed to a downstream encoder as a one-cycle result. The result carries the row index, the row word and a mask of the bits that changed. Full scans are paced by a free-running timer, so that consecutive scans start a fixed number of cycles apart.

Top module: `kbs_matrix_scan`

## Requirements
- R1: While reset is held and just after it is released, all drive lines are inactive, the amplifier enable is low, no result is produced and the row map holds zero. A first scan over an open matrix therefore produces no result.
- R2: Each sensor runs eight steps of STEP_CYC cycles each, in this order:
  1. enable low;
  2. Q low with the column address on the select input;
  3. Q high, which latches the address;
  4. Q high with the threshold code;
  5. row drive on;
  6. enable rises, with the drive on and the select at THRESH;
  7. drive off;
  8. sample.

  Enable rises exactly 3*STEP_CYC cycles after Q rises.
- R3: The select input carries column addresses COLS-1 down to 0. A low amplifier output sampled for address c sets bit c of the row word, so bit c of every result means column c is closed.
- R4: Rows are read from ROWS-1 down to 0. At most one drive line is active at a time, and drive_o bit r is the drive for row r.
- R5: When a row word differs from the map, the row is read again. When the two reads agree, the map takes the new word and a result is emitted with that word and a change mask equal to the old map word XOR the new word.
- R6: When the first and second reads of a row disagree, both are discarded and the map is unchanged. A result is emitted only if the map word is nonzero, and it carries the map word with a zero change mask.
- R7: A row read equal to its map word produces no result if the word is zero. If the word is nonzero it produces a result with a zero change mask, so held keys reach the encoder.
- R8: res_valid_o is a single-cycle pulse per emitted row. When a scan finishes in time, the next scan starts exactly SCAN_PERIOD cycles after the previous start, as measured by a free-running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sa_out_i | input | 1 | Amplifier output, low means the sensor is closed |
| sa_q_o | output | 1 | Strobe to the amplifier, a rising edge latches the column address |
| sa_en_o | output | 1 | Amplifier enable, a rising edge latches the threshold |
| sa_sel_o | output | SEL_W | Column address or threshold code |
| drive_o | output | ROWS | Row drive lines, active high |
| res_valid_o | output | 1 | Result strobe |
| res_row_o | output | $clog2(ROWS) | Row index of the result |
| res_word_o | output | COLS | Row word of the result |
| res_chg_o | output | COLS | Bits changed against the previous map word |

## Verification
Assertions check the handshake ordering on every cycle. Enable may rise only while the drive is on and the select holds the threshold, the drive may fall only while the amplifier is enabled, and Q is never low while enabled. They also check that at most one drive line is active, that results are single-cycle pulses that never report an unchanged empty row, and that a scan starts only when the timer has elapsed.

Some behaviour can only be shown by the bench's scenarios:
- the column-to-bit mapping;
- the descending row order;
- the exact step spacing;
- the map contents across scans;
- noise rejection when a first read is corrupted;
- the exact scan period.

The bench's amplifier model injects the corruption and checks the step spacing and the scan period against its own cycle counts.

// File: rtl/kbs_pkg.sv
`timescale 1ns/1ps
package kbs_pkg;

   // Steps of the per-sensor amplifier handshake, in execution order.
   typedef enum logic [2:0] {
      STP_OPEN,    // enable low
      STP_ADDR,    // strobe low, column address out
      STP_GRAB,    // strobe high: amplifier latches address
      STP_THR,     // strobe high, threshold code out
      STP_DRIVE,   // row drive on
      STP_ARM,     // enable high: threshold latched
      STP_DROP,    // row drive off
      STP_SAMPLE   // read amplifier output
   } stp_e;

   // Row-level scan control.
   typedef enum logic [2:0] {
      SC_WAIT,
      SC_READ1,
      SC_EVAL1,
      SC_READ2,
      SC_EVAL2
   } scan_e;

endpackage

// File: rtl/kbs_sense_seq.sv
`timescale 1ns/1ps
module kbs_sense_seq
   import kbs_pkg::*;
#(
   parameter int COLS     = 8,
   parameter int STEP_CYC = 2,
   parameter int SEL_W    = 4,
   parameter int THRESH   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             sa_out_i,
   output logic             sa_q_o,
   output logic             sa_en_o,
   output logic [SEL_W-1:0] sa_sel_o,
   output logic             drive_en_o,
   output logic             done_o,
   output logic [COLS-1:0]  word_o
);

   localparam int COL_W = $clog2(COLS);
   localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

   logic             busy_q;
   stp_e             stp_q;
   logic [COL_W-1:0] col_q;
   logic [CNT_W-1:0] cnt_q;
   logic [COLS-1:0]  word_q;
   logic             done_q;
   logic             step_last;

   assign step_last = (cnt_q == CNT_W'(STEP_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         stp_q  <= STP_OPEN;
         col_q  <= '0;
         cnt_q  <= '0;
         word_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            stp_q  <= STP_OPEN;
            col_q  <= COL_W'(COLS - 1);
            cnt_q  <= '0;
            word_q <= '0;
         end else if (busy_q) begin
            if (!step_last) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
               if (stp_q == STP_SAMPLE) begin
                  word_q[col_q] <= ~sa_out_i;
                  if (col_q == '0) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     col_q <= col_q - 1'b1;
                     stp_q <= STP_OPEN;
                  end
               end else begin
                  stp_q <= stp_e'(stp_q + 3'd1);
               end
            end
         end
      end
   end

   always_comb begin
      sa_en_o    = busy_q && (stp_q inside {STP_ARM, STP_DROP, STP_SAMPLE});
      sa_q_o     = !(busy_q && (stp_q == STP_ADDR));
      drive_en_o = busy_q && (stp_q inside {STP_DRIVE, STP_ARM});
      if (busy_q && (stp_q inside {STP_THR, STP_DRIVE, STP_ARM, STP_DROP, STP_SAMPLE}))
         sa_sel_o = SEL_W'(THRESH);
      else if (busy_q)
         sa_sel_o = SEL_W'(col_q);
      else
         sa_sel_o = '0;
   end

   assign done_o = done_q;
   assign word_o = word_q;

   // R2
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sa_en_o) |-> (drive_en_o && (sa_sel_o == SEL_W'(THRESH))));

   // R2
   drive_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_en_o) |-> sa_en_o);

   // R2
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sa_q_o |-> !sa_en_o);

endmodule

// File: rtl/kbs_scan_timer.sv
`timescale 1ns/1ps
module kbs_scan_timer #(
   parameter int PERIOD = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic elapsed_o
);

   localparam int TW = $clog2(PERIOD + 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear_i)
         cnt_q <= '0;
      else if (cnt_q != TW'(PERIOD - 1))
         cnt_q <= cnt_q + 1'b1;
   end

   assign elapsed_o = (cnt_q == TW'(PERIOD - 1));

   // R8
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elapsed_o && !clear_i) |=> elapsed_o);

endmodule

// File: rtl/kbs_row_map.sv
`timescale 1ns/1ps
module kbs_row_map #(
   parameter int ROWS = 12,
   parameter int COLS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(ROWS)-1:0] rd_row_i,
   output logic [COLS-1:0]         rd_word_o,
   input  logic                    wr_en_i,
   input  logic [$clog2(ROWS)-1:0] wr_row_i,
   input  logic [COLS-1:0]         wr_word_i
);

   localparam int ROW_W = $clog2(ROWS);

   logic [COLS-1:0] map_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map_q[r] <= '0;
         else if (wr_en_i && (wr_row_i == ROW_W'(r)))
            map_q[r] <= wr_word_i;
      end
   end

   always_comb begin
      rd_word_o = '0;
      for (int r = 0; r < ROWS; r++)
         if (rd_row_i == ROW_W'(r)) rd_word_o = map_q[r];
   end

   // R5
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> (wr_row_i < ROW_W'(ROWS)));

endmodule

// File: rtl/kbs_matrix_scan.sv
`timescale 1ns/1ps
module kbs_matrix_scan
   import kbs_pkg::*;
#(
   parameter int ROWS        = 12,
   parameter int COLS        = 8,
   parameter int STEP_CYC    = 2,
   parameter int SCAN_PERIOD = 4000,
   parameter int SEL_W       = 4,
   parameter int THRESH      = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sa_out_i,
   output logic                    sa_q_o,
   output logic                    sa_en_o,
   output logic [SEL_W-1:0]        sa_sel_o,
   output logic [ROWS-1:0]         drive_o,
   output logic                    res_valid_o,
   output logic [$clog2(ROWS)-1:0] res_row_o,
   output logic [COLS-1:0]         res_word_o,
   output logic [COLS-1:0]         res_chg_o
);

   localparam int ROW_W = $clog2(ROWS);

   if (ROWS < 2 || COLS < 2) begin : g_bad_dim
      $error("kbs_matrix_scan: ROWS and COLS must be at least 2");
   end
   if (SEL_W < $clog2(COLS) || THRESH >= (1 << SEL_W)) begin : g_bad_sel
      $error("kbs_matrix_scan: SEL_W too narrow for column address or threshold");
   end
   if (STEP_CYC < 1 || SCAN_PERIOD < 2) begin : g_bad_time
      $error("kbs_matrix_scan: STEP_CYC and SCAN_PERIOD out of range");
   end

   scan_e            st_q;
   logic [ROW_W-1:0] row_q;
   logic [COLS-1:0]  first_q;
   logic             seq_start_q;
   logic             seq_done;
   logic             seq_drive;
   logic [COLS-1:0]  seq_word;
   logic [COLS-1:0]  map_word;
   logic             map_we;
   logic             tmr_elapsed;
   logic             tmr_clr;
   logic             adv;
   logic             emit;
   logic [COLS-1:0]  e_word;
   logic [COLS-1:0]  e_chg;

   kbs_sense_seq #(
      .COLS(COLS), .STEP_CYC(STEP_CYC), .SEL_W(SEL_W), .THRESH(THRESH)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(seq_start_q), .sa_out_i(sa_out_i),
      .sa_q_o(sa_q_o), .sa_en_o(sa_en_o), .sa_sel_o(sa_sel_o),
      .drive_en_o(seq_drive), .done_o(seq_done), .word_o(seq_word)
   );

   kbs_scan_timer #(.PERIOD(SCAN_PERIOD)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear_i(tmr_clr), .elapsed_o(tmr_elapsed)
   );

   kbs_row_map #(.ROWS(ROWS), .COLS(COLS)) u_map (
      .clk(clk), .rst_n(rst_n), .rd_row_i(row_q), .rd_word_o(map_word),
      .wr_en_i(map_we), .wr_row_i(row_q), .wr_word_i(seq_word)
   );

   assign tmr_clr = (st_q == SC_WAIT) && tmr_elapsed;

   for (genvar r = 0; r < ROWS; r++) begin : g_drv
      assign drive_o[r] = seq_drive && (row_q == ROW_W'(r));
   end

   always_comb begin
      adv    = 1'b0;
      emit   = 1'b0;
      map_we = 1'b0;
      e_word = seq_word;
      e_chg  = '0;
      case (st_q)
         SC_EVAL1: begin
            if (seq_word == map_word) begin
               adv  = 1'b1;
               emit = (seq_word != '0);
            end
         end
         SC_EVAL2: begin
            adv = 1'b1;
            if (seq_word == first_q) begin
               map_we = 1'b1;
               emit   = 1'b1;
               e_chg  = seq_word ^ map_word;
            end else begin
               emit   = (map_word != '0);
               e_word = map_word;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= SC_WAIT;
         row_q       <= ROW_W'(ROWS - 1);
         first_q     <= '0;
         seq_start_q <= 1'b0;
         res_valid_o <= 1'b0;
         res_row_o   <= '0;
         res_word_o  <= '0;
         res_chg_o   <= '0;
      end else begin
         seq_start_q <= 1'b0;
         res_valid_o <= 1'b0;
         case (st_q)
            SC_WAIT: if (tmr_elapsed) begin
               row_q       <= ROW_W'(ROWS - 1);
               seq_start_q <= 1'b1;
               st_q        <= SC_READ1;
            end
            SC_READ1: if (seq_done) st_q <= SC_EVAL1;
            SC_EVAL1: if (!adv) begin
               first_q     <= seq_word;
               seq_start_q <= 1'b1;
               st_q        <= SC_READ2;
            end
            SC_READ2: if (seq_done) st_q <= SC_EVAL2;
            default: ;
         endcase
         if (adv) begin
            if (row_q == '0) begin
               st_q <= SC_WAIT;
            end else begin
               row_q       <= row_q - 1'b1;
               seq_start_q <= 1'b1;
               st_q        <= SC_READ1;
            end
         end
         if (emit) begin
            res_valid_o <= 1'b1;
            res_row_o   <= row_q;
            res_word_o  <= e_word;
            res_chg_o   <= e_chg;
         end
      end
   end

   // R4
   drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive_o));

   // R8
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |=> !res_valid_o);

   // R7
   res_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && (res_chg_o == '0)) |-> (res_word_o != '0));

   // R8
   scan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SC_READ1) && ($past(st_q) == SC_WAIT)) |-> $past(tmr_elapsed));

endmodule

// File: tb/kbs_matrix_scan_tb_top.sv
`timescale 1ns/1ps
module kbs_matrix_scan_tb_top;

   localparam int ROWS   = 12;
   localparam int COLS   = 8;
   localparam int STEP   = 2;
   localparam int PERIOD = 4000;
   localparam int SEL_W  = 4;
   localparam int THR    = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sa_out = 1'b1;
   logic             sa_q, sa_en;
   logic [SEL_W-1:0] sa_sel;
   logic [ROWS-1:0]  drive;
   logic             res_valid;
   logic [3:0]       res_row;
   logic [7:0]       res_word, res_chg;

   always #2.5 clk = ~clk;

   kbs_matrix_scan #(
      .ROWS(ROWS), .COLS(COLS), .STEP_CYC(STEP), .SCAN_PERIOD(PERIOD),
      .SEL_W(SEL_W), .THRESH(THR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sa_out_i(sa_out), .sa_q_o(sa_q), .sa_en_o(sa_en),
      .sa_sel_o(sa_sel), .drive_o(drive), .res_valid_o(res_valid),
      .res_row_o(res_row), .res_word_o(res_word), .res_chg_o(res_chg)
   );

   int          checks = 0;
   int          fails = 0;
   longint      cyc = 0;
   logic [7:0]  keys [ROWS];
   logic [7:0]  mdl_map [ROWS];
   bit          flaky_arm = 1'b0;
   int          flaky_row = 0;
   logic [7:0]  flaky_mask = 8'h00;
   logic [19:0] exp_q [$];
   string       tag_q [$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // Sense amplifier model with protocol checks
   logic             q_prev = 1'b1, en_prev = 1'b0;
   logic [ROWS-1:0]  drv_prev = '0;
   logic [SEL_W-1:0] addr_l = '0;
   longint           t_grab = 0;
   int               row_l = 0;
   int               last_row = 0;
   int               exp_addr = COLS - 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sa_q && !q_prev) begin
            addr_l = sa_sel;
            t_grab = cyc;
         end
         if (sa_en && !en_prev) begin
            chk(sa_sel == SEL_W'(THR), "R2", "threshold at enable", 32'(sa_sel), THR);
            chk(cyc - t_grab == 3 * STEP, "R2", "strobe-to-enable cycles",
                32'(cyc - t_grab), 3 * STEP);
            chk($onehot(drive), "R4", "single drive at enable", 32'(drive), 0);
            for (int r = 0; r < ROWS; r++) if (drive[r]) row_l = r;
            if (row_l != last_row) begin
               chk(row_l == ((last_row == 0) ? ROWS - 1 : last_row - 1), "R4",
                   "row order", row_l, (last_row == 0) ? ROWS - 1 : last_row - 1);
               last_row = row_l;
            end
         end
         if (!sa_en) sa_out = 1'b1;
         if (sa_en && drv_prev != '0 && drive == '0) begin
            logic [7:0] w;
            chk(addr_l == SEL_W'(exp_addr), "R3", "column address order", 32'(addr_l), exp_addr);
            exp_addr = (exp_addr == 0) ? COLS - 1 : exp_addr - 1;
            w = keys[row_l];
            if (flaky_arm && row_l == flaky_row) begin
               w = w | flaky_mask;
               if (addr_l == 0) flaky_arm = 1'b0;
            end
            sa_out = !w[addr_l[2:0]];
         end
      end
      q_prev   = sa_q;
      en_prev  = sa_en;
      drv_prev = drive;
   end

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected result row", 32'(res_row), 0);
         end else begin
            logic [19:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({res_row, res_word, res_chg} == e, t, "result {row,word,chg}",
                {12'h0, res_row, res_word, res_chg}, {12'h0, e});
         end
      end
   end

   task automatic push_expected();
      for (int r = ROWS - 1; r >= 0; r--) begin
         logic [7:0] r1, r2, m;
         r2 = keys[r];
         r1 = (flaky_arm && flaky_row == r) ? (r2 | flaky_mask) : r2;
         m  = mdl_map[r];
         if (r1 == m) begin
            if (m != 0) begin exp_q.push_back({4'(r), m, 8'h00}); tag_q.push_back("R7"); end
         end else if (r1 == r2) begin
            exp_q.push_back({4'(r), r2, r2 ^ m}); tag_q.push_back("R5");
            mdl_map[r] = r2;
         end else if (m != 0) begin
            exp_q.push_back({4'(r), m, 8'h00}); tag_q.push_back("R6");
         end
      end
   endtask

   longint last_start = -1;

   task automatic run_scan(input string tag);
      push_expected();
      while (drive == '0) @(negedge clk);
      if (last_start >= 0)
         chk(cyc - last_start == PERIOD, "R8", "scan start spacing",
             32'(cyc - last_start), PERIOD);
      last_start = cyc;
      begin
         int idle = 0;
         while (idle < 64) begin
            @(negedge clk);
            idle = (drive == '0) ? idle + 1 : 0;
         end
      end
      chk(exp_q.size() == 0, tag, "expected results left after scan", exp_q.size(), 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      for (int r = 0; r < ROWS; r++) begin keys[r] = 8'h00; mdl_map[r] = 8'h00; end
      repeat (10) @(negedge clk);
      chk(drive == '0, "R1", "drive in reset", 32'(drive), 0);
      chk(!sa_en && !res_valid, "R1", "enable/valid in reset", {sa_en, res_valid}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(drive == '0 && !res_valid, "R1", "idle after reset", 32'(drive), 0);
      // open matrix: cleared map means nothing reported
      run_scan("R1");
      // corner columns on top and bottom rows
      keys[11] = 8'h80; keys[0] = 8'h01;
      run_scan("R3");
      // held keys
      run_scan("R7");
      // release one, press a pattern on another
      keys[11] = 8'h00; keys[5] = 8'hA5;
      run_scan("R5");
      // noise on an empty row: dropped, nothing reported
      flaky_arm = 1'b1; flaky_row = 3; flaky_mask = 8'h10;
      run_scan("R6");
      // noise on a held row: map word kept
      flaky_arm = 1'b1; flaky_row = 5; flaky_mask = 8'h02;
      run_scan("R6");
      // every row changes
      for (int r = 0; r < ROWS; r++) keys[r] = 8'(r * 37 + 5);
      run_scan("R5");
      run_scan("R7");
      // release everything
      for (int r = 0; r < ROWS; r++) keys[r] = 8'h00;
      run_scan("R5");
      run_scan("R7");
      summary();
      $finish;
   end

endmodule